// File: doc/BRIEF.md
# Addressed Nibble Configuration Latch Bank

This block is the programming port of a frequency synthesizer. A host drives a 4-bit data bus, a 3-bit slot address and a strobe. Eight internal slots, each at most one nibble wide, take the bus value. Together the slots form three divide values with odd widths: a 7-bit swallow count (A), a 10-bit main count (N) and a 12-bit reference count (R). The three values go out as parallel buses to the divider logic.

The strobe, address and data are brought into the system clock domain together through one synchronizer. While the synchronized strobe is high, the addressed slot is rewritten on every clock. When the strobe falls, the slot keeps the last value it took. The strobe should rest low so that the bus can change without any effect. An asynchronous active-low reset clears every slot to zero. The reset is released in step with the clock.

Top module: `nib_cfg_bank`

## Requirements
- R1: While reset is applied, and until its synchronized release, all three outputs are zero.
- R2: Slot 0 (address 000) loads A[3:0] from data[3:0], and slot 1 (address 001) loads A[6:4] from data[2:0]. data[3] is the most significant bus bit.
- R3: Slot 2 loads N[3:0], slot 3 loads N[7:4], and slot 4 (address 100) loads N[9:8] from data[1:0].
- R4: Slot 5 loads R[3:0], slot 6 loads R[7:4], and slot 7 (address 111) loads R[11:8].
- R5: While the strobe is high, the addressed slot follows the bus on every clock. After the strobe falls, the slot holds the last value it took.
- R6: While the strobe is low, no output changes, whatever the address and data do.
- R7: data[3] at address 001 and data[3:2] at address 100 are ignored.
- R8: A write changes only the addressed slot. All other output bits keep their values.
- R9: An input change shows on the outputs exactly SYNC_STAGES+1 rising clock edges after it is presented (3 edges by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Load strobe, active high, rests low |
| addr_i | input | 3 | Slot address |
| data_i | input | 4 | Nibble data bus, bit 3 is the most significant |
| a_val_o | output | 7 | Swallow count value |
| n_val_o | output | 10 | Main count value |
| r_val_o | output | 12 | Reference count value |

## Verification
The hardest case to reach from the ports is a strobe that stays high for many clocks while the bus keeps changing. Here the slot must track every value and then keep exactly the one that was present at the clock before the synchronized strobe dropped. The bench holds the strobe high at one address and steps the data through all sixteen codes. It then lowers the strobe and changes the data on the same edge. A behavioural model with the same input latency is compared against the outputs on every clock, so the check covers the tracking, the freeze and the way the address and data are aligned with the strobe.

// File: rtl/nib_cfg_pkg.sv
package nib_cfg_pkg;
  localparam int NIB_W     = 4;
  localparam int NUM_SLOTS = 8;
  localparam int ADDR_W    = $clog2(NUM_SLOTS);
  localparam int A_W       = 7;
  localparam int N_W       = 10;
  localparam int R_W       = 12;
  localparam int CFG_W     = A_W + N_W + R_W;
  localparam int A_SLOTS   = (A_W + NIB_W - 1) / NIB_W;
  localparam int N_SLOTS   = (N_W + NIB_W - 1) / NIB_W;

  // width of the field piece a slot stores
  function automatic int slot_width(input int s);
    int k;
    int fw;
    if (s < A_SLOTS) begin
      k = s; fw = A_W;
    end else if (s < A_SLOTS + N_SLOTS) begin
      k = s - A_SLOTS; fw = N_W;
    end else begin
      k = s - A_SLOTS - N_SLOTS; fw = R_W;
    end
    return ((fw - k * NIB_W) < NIB_W) ? (fw - k * NIB_W) : NIB_W;
  endfunction

  // bit offset of a slot inside the packed {R,N,A} vector
  function automatic int slot_base(input int s);
    int b;
    b = 0;
    for (int i = 0; i < s; i++) b += slot_width(i);
    return b;
  endfunction
endpackage

// File: rtl/nib_cfg_rst_sync.sv
module nib_cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q = chain_q[STAGES-1];
endmodule

// File: rtl/nib_cfg_sync.sv
module nib_cfg_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] stage_d;
      if (g == 0) begin : g_first
        always_comb stage_d = d;
      end else begin : g_next
        always_comb stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_d;
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/nib_cfg_decode.sv
module nib_cfg_decode #(
  parameter int SLOTS  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              strobe,
  input  logic [ADDR_W-1:0] addr,
  output logic [SLOTS-1:0]  we
);
  always_comb begin
    we = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (strobe && (addr == ADDR_W'(i))) we[i] = 1'b1;
    end
  end
endmodule

// File: rtl/nib_cfg_slot.sv
module nib_cfg_slot #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] val_q;
  logic [W-1:0] val_d;

  always_comb begin
    val_d = val_q;
    if (we) val_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign q = val_q;
endmodule

// File: rtl/nib_cfg_bank.sv
module nib_cfg_bank #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            strobe_i,
  input  logic [nib_cfg_pkg::ADDR_W-1:0]  addr_i,
  input  logic [nib_cfg_pkg::NIB_W-1:0]   data_i,
  output logic [nib_cfg_pkg::A_W-1:0]     a_val_o,
  output logic [nib_cfg_pkg::N_W-1:0]     n_val_o,
  output logic [nib_cfg_pkg::R_W-1:0]     r_val_o
);
  import nib_cfg_pkg::*;

  localparam int BUS_W = 1 + ADDR_W + NIB_W;

  logic                 rst_q;
  logic [BUS_W-1:0]     bus_s;
  logic                 stb_s;
  logic [ADDR_W-1:0]    addr_s;
  logic [NIB_W-1:0]     data_s;
  logic [NUM_SLOTS-1:0] we;
  logic [CFG_W-1:0]     cfg;

  nib_cfg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q(rst_q)
  );

  nib_cfg_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_q),
    .d({strobe_i, addr_i, data_i}),
    .q(bus_s)
  );

  assign {stb_s, addr_s, data_s} = bus_s;

  nib_cfg_decode #(.SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_dec (
    .strobe(stb_s), .addr(addr_s), .we(we)
  );

  genvar s;
  generate
    for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
      localparam int SW = slot_width(s);
      localparam int SB = slot_base(s);
      logic [SW-1:0] slot_q;
      nib_cfg_slot #(.W(SW)) u_slot (
        .clk(clk), .rst_n(rst_q), .we(we[s]),
        .d(data_s[SW-1:0]), .q(slot_q)
      );
      assign cfg[SB +: SW] = slot_q;
    end
  endgenerate

  assign a_val_o = cfg[A_W-1:0];
  assign n_val_o = cfg[A_W +: N_W];
  assign r_val_o = cfg[A_W+N_W +: R_W];
endmodule

module nib_cfg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rst_q,
  input logic        stb_s,
  input logic [2:0]  addr_s,
  input logic [3:0]  data_s,
  input logic [7:0]  we,
  input logic [6:0]  a_val_o,
  input logic [9:0]  n_val_o,
  input logic [11:0] r_val_o
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_q |-> ({a_val_o, n_val_o, r_val_o} == '0));

  p_one_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q && !stb_s) |=> $stable({a_val_o, n_val_o, r_val_o}));

  p_a_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q && stb_s && addr_s == 3'd0) |=> (a_val_o[3:0] == $past(data_s)));

  p_n_mid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q && stb_s && addr_s == 3'd3) |=> (n_val_o[7:4] == $past(data_s)));

  p_r_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q && stb_s && addr_s == 3'd7) |=> (r_val_o[11:8] == $past(data_s)));

  p_n_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q && stb_s && addr_s == 3'd4) |=>
      (n_val_o[9:8] == $past(data_s[1:0]) && n_val_o[7:0] == $past(n_val_o[7:0])));
endmodule

bind nib_cfg_bank nib_cfg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rst_q(rst_q), .stb_s(stb_s),
  .addr_s(addr_s), .data_s(data_s), .we(we),
  .a_val_o(a_val_o), .n_val_o(n_val_o), .r_val_o(r_val_o)
);

// File: tb/nib_cfg_bank_tb.sv
`timescale 1ns/1ps
module nib_cfg_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        strobe_i;
  logic [2:0]  addr_i;
  logic [3:0]  data_i;
  logic [6:0]  a_val_o;
  logic [9:0]  n_val_o;
  logic [11:0] r_val_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  nib_cfg_bank u_dut (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .addr_i(addr_i),
    .data_i(data_i), .a_val_o(a_val_o), .n_val_o(n_val_o), .r_val_o(r_val_o)
  );

  // behavioural model: inputs delayed by two edges, applied on the third (R9)
  logic [7:0] inq [$];
  logic [3:0] mem [8];

  function automatic logic [28:0] model_cfg();
    logic [6:0]  a;
    logic [9:0]  n;
    logic [11:0] r;
    a = {mem[1][2:0], mem[0]};
    n = {mem[4][1:0], mem[3], mem[2]};
    r = {mem[7], mem[6], mem[5]};
    return {r, n, a};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inq.delete();
      inq.push_back(8'h00);
      inq.push_back(8'h00);
      for (int i = 0; i < 8; i++) mem[i] = 4'h0;
    end else begin
      logic [7:0] e;
      inq.push_back({strobe_i, addr_i, data_i});
      e = inq.pop_front();
      if (e[7]) mem[e[6:4]] = e[3:0];
    end
  end

  // per-clock comparison (R9 and every other requirement)
  always @(negedge clk) begin
    logic [28:0] exp_v;
    cycles++;
    if (rst_n === 1'b1) begin
      exp_v = model_cfg();
      checks++;
      if ({r_val_o, n_val_o, a_val_o} !== exp_v) begin
        errors++;
        $display("FAIL %s R9 per-clock: actual %h expected %h", cur_req,
                 {r_val_o, n_val_o, a_val_o}, exp_v);
      end
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_nib(input logic [2:0] a, input logic [3:0] d);
    @(negedge clk);
    strobe_i = 1'b1; addr_i = a; data_i = d;
    @(negedge clk);
    strobe_i = 1'b0; data_i = ~d;
    idle(4);
  endtask

  initial begin
    rst_n = 1'b0; strobe_i = 1'b0; addr_i = 3'd0; data_i = 4'd0;
    idle(3);
    cur_req = "R1";
    check("R1 reset A", 32'(a_val_o), 32'h0);
    check("R1 reset N", 32'(n_val_o), 32'h0);
    check("R1 reset R", 32'(r_val_o), 32'h0);
    rst_n = 1'b1;
    idle(4);

    cur_req = "R2";
    write_nib(3'd0, 4'hA);
    write_nib(3'd1, 4'hF);
    check("R2/R7 A value", 32'(a_val_o), 32'h7A);

    cur_req = "R3";
    write_nib(3'd2, 4'h3);
    write_nib(3'd3, 4'hC);
    write_nib(3'd4, 4'hE);
    check("R3/R7 N value", 32'(n_val_o), 32'h2C3);
    check("R8 A untouched by N writes", 32'(a_val_o), 32'h7A);

    cur_req = "R4";
    write_nib(3'd5, 4'h1);
    write_nib(3'd6, 4'h2);
    write_nib(3'd7, 4'h9);
    check("R4 R value", 32'(r_val_o), 32'h921);
    check("R8 N untouched by R writes", 32'(n_val_o), 32'h2C3);

    cur_req = "R6";
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      addr_i = 3'(i); data_i = 4'(i * 7);
    end
    idle(4);
    check("R6 A held", 32'(a_val_o), 32'h7A);
    check("R6 N held", 32'(n_val_o), 32'h2C3);
    check("R6 R held", 32'(r_val_o), 32'h921);

    cur_req = "R5";
    @(negedge clk);
    strobe_i = 1'b1; addr_i = 3'd6;
    for (int i = 0; i < 16; i++) begin
      data_i = 4'(i);
      @(negedge clk);
    end
    data_i = 4'h5;
    @(negedge clk);
    strobe_i = 1'b0; data_i = 4'hB;
    idle(5);
    check("R5 last value kept", 32'(r_val_o), 32'h951);
    check("R8 A unchanged", 32'(a_val_o), 32'h7A);

    cur_req = "R7";
    write_nib(3'd1, 4'h8);
    check("R7 A D3 ignored", 32'(a_val_o), 32'h0A);
    write_nib(3'd4, 4'hD);
    check("R7 N D3:D2 ignored", 32'(n_val_o), 32'h1C3);

    cur_req = "R1";
    @(negedge clk);
    rst_n = 1'b0;
    idle(1);
    check("R1 mid-run reset A", 32'(a_val_o), 32'h0);
    check("R1 mid-run reset N", 32'(n_val_o), 32'h0);
    check("R1 mid-run reset R", 32'(r_val_o), 32'h0);
    rst_n = 1'b1;
    idle(4);
    cur_req = "R2";
    write_nib(3'd0, 4'h6);
    check("R2 write after reset", 32'(a_val_o), 32'h06);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule